// File: doc/BRIEF.md
# Condition Register Field File

A 32-bit condition register organised as eight 4-bit fields. Field 0 sits in the most significant nibble and field 7 in the least significant one. Bits are numbered big-endian: bit index 0 is word bit 31 and bit index 31 is word bit 0.

The block has several write ports, each with its own enable:
- a single-bit write addressed by bit index;
- a field write that loads any set of fields from a 32-bit word under an 8-bit mask;
- a record-form update of field 0, taken from the signed comparison of an arithmetic result with zero together with the current summary-overflow bit.

When ports collide, the choice is made per field with a fixed priority. A lower-priority port still lands in every field that no higher-priority port claims.

The whole register is always visible as one word. A single bit can also be read by index.

Top module: `cr_field_file`

## Requirements
- R1: While rst_ni is low, and after its release until the first write, cr_o is 32'h0000_0000.
- R2: Field n occupies cr_o bits 4*(7-n)+3 down to 4*(7-n). cr_o follows the stored value with no extra cycle: a write seen at a rising edge is visible right after that edge.
- R3: Bit index i (0..31) selects field i/4 and position i%4 in that field, which is cr_o bit 31-i. Positions 0, 1, 2 and 3 are LT, GT, EQ and SO, from the field's MSB down to its LSB. rd_bit_o is combinationally cr_o bit 31-rd_idx_i.
- R4: A single-bit write (bit_we_i) sets cr_o bit 31-bit_idx_i to bit_val_i and leaves the other 31 bits unchanged.
- R5: A field write (fld_we_i) loads field n from fld_word_i bits 4*(7-n)+3..4*(7-n) for every n where fld_mask_i bit 7-n is 1. Fields whose mask bit is 0 keep their value.
- R6: A record update (rec_we_i) sets field 0 from rec_result_i taken as a signed value: LT (cr_o[31]) when it is negative, GT (cr_o[30]) when it is positive, EQ (cr_o[29]) when it is zero. Exactly one of the three is 1.
- R7: A record update copies so_i into field 0's SO bit (cr_o[28]).
- R8: Within each field the priority is record update (field 0 only), then field write, then single-bit write. A lower-priority port still writes any field that no higher-priority port touches in the same cycle.
- R9: In a cycle with no write enable asserted, cr_o does not change, whatever the data, index and read inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_we_i | input | 1 | Single-bit write enable |
| bit_idx_i | input | 5 | Big-endian bit index for the write |
| bit_val_i | input | 1 | Value for the single-bit write |
| fld_we_i | input | 1 | Field write enable |
| fld_mask_i | input | 8 | Field enables; bit 7-n selects field n |
| fld_word_i | input | 32 | Source word for the field write |
| rec_we_i | input | 1 | Record-form field 0 update enable |
| rec_result_i | input | 32 | Signed result compared with zero |
| so_i | input | 1 | Current summary-overflow bit |
| rd_idx_i | input | 5 | Big-endian bit index for the read |
| rd_bit_o | output | 1 | Addressed bit |
| cr_o | output | 32 | Whole register |

## Verification
A wrong value inside a field reaches cr_o right after the edge that stores it, so every write is checked one cycle after it is issued, against a word model kept in the bench. A write that lands in the wrong field, or in the wrong bit of a field, shows up as a mismatch outside the intended nibble at that same sample. Priority errors are exposed by cycles in which several ports aim at the same field and at different fields. Every bit index is then read back through rd_bit_o, which catches a wrong index mapping on the read side.

// File: rtl/cr_pkg.sv
`timescale 1ns/1ps
package cr_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned CR_W       = NUM_FIELDS * FIELD_W;
  localparam int unsigned IDX_W      = $clog2(CR_W);
  localparam int unsigned FSEL_W     = $clog2(NUM_FIELDS);
  localparam int unsigned POS_W      = $clog2(FIELD_W);

  typedef logic [FIELD_W-1:0] nib_t;

  // nibble bit positions (LSB = 0)
  localparam int unsigned NB_LT = 3;
  localparam int unsigned NB_GT = 2;
  localparam int unsigned NB_EQ = 1;
  localparam int unsigned NB_SO = 0;
endpackage

// File: rtl/cr_bit_sel.sv
`timescale 1ns/1ps
module cr_bit_sel
  import cr_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  output logic [FSEL_W-1:0] field_o,
  output logic [POS_W-1:0]  nib_bit_o
);
  // big-endian: position p within field maps to nibble bit FIELD_W-1-p
  assign field_o   = idx_i[IDX_W-1:POS_W];
  assign nib_bit_o = POS_W'(FIELD_W - 1) - idx_i[POS_W-1:0];
endmodule

// File: rtl/cr_rec_gen.sv
`timescale 1ns/1ps
module cr_rec_gen
  import cr_pkg::*;
#(
  parameter int unsigned RES_W = 32
) (
  input  logic [RES_W-1:0] result_i,
  input  logic             so_i,
  output nib_t             nib_o
);
  logic neg, zero;
  assign neg  = result_i[RES_W-1];
  assign zero = (result_i == '0);

  always_comb begin
    nib_o        = '0;
    nib_o[NB_LT] = neg;
    nib_o[NB_GT] = ~neg & ~zero;
    nib_o[NB_EQ] = zero;
    nib_o[NB_SO] = so_i;
  end
endmodule

// File: rtl/cr_field_slot.sv
`timescale 1ns/1ps
module cr_field_slot
  import cr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_we_i,
  input  nib_t             rec_nib_i,
  input  logic             fld_en_i,
  input  nib_t             fld_nib_i,
  input  logic             bit_hit_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic             bit_val_i,
  output nib_t             nib_o
);
  nib_t nib_q, nib_d;

  always_comb begin
    nib_d = nib_q;
    if (rec_we_i)       nib_d = rec_nib_i;
    else if (fld_en_i)  nib_d = fld_nib_i;
    else if (bit_hit_i) nib_d[bit_pos_i] = bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nib_q <= '0;
    else         nib_q <= nib_d;
  end

  assign nib_o = nib_q;

  AST_SLOT_REC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_we_i |=> nib_q == $past(rec_nib_i)); // R8
  AST_SLOT_FLD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_en_i && !rec_we_i) |=> nib_q == $past(fld_nib_i)); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_we_i && !fld_en_i && !bit_hit_i) |=> $stable(nib_q)); // R9
endmodule

// File: rtl/cr_field_file.sv
`timescale 1ns/1ps
module cr_field_file
  import cr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_we_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  input  logic             fld_we_i,
  input  logic [NUM_FIELDS-1:0] fld_mask_i,
  input  logic [CR_W-1:0]  fld_word_i,
  input  logic             rec_we_i,
  input  logic [CR_W-1:0]  rec_result_i,
  input  logic             so_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_bit_o,
  output logic [CR_W-1:0]  cr_o
);
  logic [FSEL_W-1:0] wr_field, rd_field;
  logic [POS_W-1:0]  wr_pos, rd_pos;
  nib_t              rec_nib;
  nib_t              fld_q [NUM_FIELDS];

  cr_bit_sel u_wr_sel (.idx_i(bit_idx_i), .field_o(wr_field), .nib_bit_o(wr_pos));
  cr_bit_sel u_rd_sel (.idx_i(rd_idx_i),  .field_o(rd_field), .nib_bit_o(rd_pos));

  cr_rec_gen #(.RES_W(CR_W)) u_rec (
    .result_i(rec_result_i), .so_i(so_i), .nib_o(rec_nib)
  );

  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_field
    localparam int unsigned LSB = FIELD_W * (NUM_FIELDS - 1 - n);
    cr_field_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rec_we_i  (rec_we_i && (n == 0)),
      .rec_nib_i (rec_nib),
      .fld_en_i  (fld_we_i && fld_mask_i[NUM_FIELDS-1-n]),
      .fld_nib_i (fld_word_i[LSB +: FIELD_W]),
      .bit_hit_i (bit_we_i && (wr_field == FSEL_W'(n))),
      .bit_pos_i (wr_pos),
      .bit_val_i (bit_val_i),
      .nib_o     (fld_q[n])
    );
    assign cr_o[LSB +: FIELD_W] = fld_q[n];
  end

  assign rd_bit_o = fld_q[rd_field][rd_pos];

  AST_REC_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_we_i |=> $countones(cr_o[CR_W-1 -: 3]) == 1); // R6
  AST_REC_SO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_we_i |=> cr_o[CR_W-FIELD_W] == $past(so_i)); // R7
  AST_BIT_ONLY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && !fld_we_i && !rec_we_i) |=>
      (((cr_o ^ $past(cr_o)) & ~({{(CR_W-1){1'b0}}, 1'b1} << (CR_W-1-$past(bit_idx_i)))) == '0)
      && (cr_o[CR_W-1-$past(bit_idx_i)] == $past(bit_val_i))); // R4
  AST_RD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_bit_o == cr_o[CR_W-1-rd_idx_i]); // R3
endmodule

// File: tb/cr_field_file_bench.sv
`timescale 1ns/1ps
module cr_field_file_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_we_i = 1'b0;
  logic [4:0]  bit_idx_i = '0;
  logic        bit_val_i = 1'b0;
  logic        fld_we_i = 1'b0;
  logic [7:0]  fld_mask_i = '0;
  logic [31:0] fld_word_i = '0;
  logic        rec_we_i = 1'b0;
  logic [31:0] rec_result_i = '0;
  logic        so_i = 1'b0;
  logic [4:0]  rd_idx_i = '0;
  logic        rd_bit_o;
  logic [31:0] cr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_cr = '0;

  cr_field_file u_cr_field_file (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  // one cycle with any mix of ports; model applies low to high priority
  task automatic drive(string tag,
                       logic rw, logic [31:0] res, logic so,
                       logic fw, logic [7:0] msk, logic [31:0] wd,
                       logic bw, logic [4:0] idx, logic val);
    rec_we_i = rw; rec_result_i = res; so_i = so;
    fld_we_i = fw; fld_mask_i = msk; fld_word_i = wd;
    bit_we_i = bw; bit_idx_i = idx; bit_val_i = val;
    if (bw) exp_cr[31-idx] = val;
    if (fw)
      for (int n = 0; n < 8; n++)
        if (msk[7-n]) exp_cr[4*(7-n) +: 4] = wd[4*(7-n) +: 4];
    if (rw) begin
      exp_cr[31] = res[31];
      exp_cr[30] = !res[31] && (res != 0);
      exp_cr[29] = (res == 0);
      exp_cr[28] = so;
    end
    cyc();
    rec_we_i = 1'b0; fld_we_i = 1'b0; bit_we_i = 1'b0;
    chk(tag, cr_o, exp_cr);
  endtask

  task automatic t_reset();
    chk("R1 during reset", cr_o, 32'h0);
    rst_ni = 1'b1;
    cyc();
    chk("R1 after release", cr_o, 32'h0);
  endtask

  task automatic t_field();
    drive("R5 all fields", 0, 0, 0, 1, 8'hFF, 32'h1234_5678, 0, 0, 0);
    for (int n = 0; n < 8; n++)
      drive("R2 R5 single field", 0, 0, 0, 1, 8'h80 >> n, 32'hFFFF_FFFF ^ (32'h1 << (4*(7-n))), 0, 0, 0);
    drive("R5 sparse mask", 0, 0, 0, 1, 8'hA5, 32'h0000_0000, 0, 0, 0);
    drive("R5 zero mask", 0, 0, 0, 1, 8'h00, 32'hDEAD_BEEF, 0, 0, 0);
  endtask

  task automatic t_bits();
    drive("R5 clear", 0, 0, 0, 1, 8'hFF, 32'h0, 0, 0, 0);
    for (int i = 0; i < 32; i++) drive("R4 set bit", 0, 0, 0, 0, 0, 0, 1, 5'(i), 1);
    for (int i = 31; i >= 0; i -= 3) drive("R4 clear bit", 0, 0, 0, 0, 0, 0, 1, 5'(i), 0);
    drive("R3 idx0 is msb", 0, 0, 0, 0, 0, 0, 1, 5'd0, 1);
  endtask

  task automatic t_read();
    drive("R5 pattern", 0, 0, 0, 1, 8'hFF, 32'hC3A5_0F96, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin
      rd_idx_i = 5'(i);
      #1;
      chk("R3 read bit", {31'b0, rd_bit_o}, {31'b0, exp_cr[31-i]});
    end
  endtask

  task automatic t_rec();
    drive("R6 negative", 1, 32'hFFFF_FFF0, 0, 0, 0, 0, 0, 0, 0);
    drive("R6 R7 positive so", 1, 32'h0000_0001, 1, 0, 0, 0, 0, 0, 0);
    drive("R6 zero", 1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    drive("R6 most negative", 1, 32'h8000_0000, 1, 0, 0, 0, 0, 0, 0);
    drive("R6 most positive", 1, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_prio();
    drive("R5 preset", 0, 0, 0, 1, 8'hFF, 32'h0, 0, 0, 0);
    drive("R8 rec over mask, bit elsewhere", 1, 32'h5, 0, 1, 8'h80, 32'hF000_0000, 1, 5'd5, 1);
    drive("R8 mask over bit", 0, 0, 0, 1, 8'h40, 32'h0A00_0000, 1, 5'd4, 0);
    drive("R8 rec over bit", 1, 32'h0, 1, 0, 0, 0, 1, 5'd0, 1);
    drive("R8 mask and bit split", 0, 0, 0, 1, 8'h01, 32'h0000_0009, 1, 5'd1, 1);
    drive("R8 all three", 1, 32'h8000_0001, 0, 1, 8'hC0, 32'h5500_0000, 1, 5'd10, 1);
  endtask

  task automatic t_hold();
    logic [31:0] snap;
    snap = cr_o;
    for (int k = 0; k < 6; k++) begin
      fld_word_i = 32'hA5A5_0000 + 32'(k); fld_mask_i = 8'hFF;
      rec_result_i = 32'(k); so_i = k[0];
      bit_idx_i = 5'(k * 5); bit_val_i = ~k[0]; rd_idx_i = 5'(k);
      cyc();
      chk("R9 hold", cr_o, snap);
    end
    drive("R2 write visible next edge", 0, 0, 0, 0, 0, 0, 1, 5'd31, ~exp_cr[0]);
  endtask

  initial begin
    #5;
    t_reset();
    t_field();
    t_bits();
    t_read();
    t_rec();
    t_prio();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule